// File: doc/BRIEF.md
# Windowed Watchdog Timer with Power-Mode Gating

This block counts slow-clock ticks and raises a one-cycle reset request if software does not restart it in time. The slow clock arrives as a single-cycle enable tick in the system clock domain, so the whole block runs on one clock. A 3-bit period code sets the overflow point to one of eight power-of-two tick counts. A 2-bit window code sets how much of the end of that period is "open" for a restart.

Software restarts the count by writing the key byte 0xAC on an 8-bit write port while the window is open. A key written while the window is closed, or any other byte written at any time, is treated as a fault and causes an immediate reset request. A static policy bit chooses what happens in the low-power modes. With the bit clear, halt, stop and a stopped slow oscillator freeze the count, and it resumes from the held value. With the bit set, counting goes on in every mode.

Top module: `wdt_win`

## Requirements
- R1: With period code p (0..7), the reset request rises after exactly 2^(MIN_EXP+p) counting ticks from a zero count (MIN_EXP defaults to 10). A cycle with tick_i low does not advance the count.
- R2: `rst_req_o` is a single-cycle pulse. After it the count is zero, so the next overflow again needs the full period.
- R3: A write of 0xAC while `win_open_o` is high clears the count to zero without a reset request. The full period is then needed before the next overflow.
- R4: A write of 0xAC while `win_open_o` is low causes `rst_req_o` high on the cycle after the write.
- R5: A write of any byte other than 0xAC causes `rst_req_o` high on the cycle after the write, whether or not the window is open.
- R6: With window code w (0..3), `win_open_o` is high when the count is at least (3-w)/4 of the period. Code 0 opens only the last quarter, and code 3 is always open.
- R7: With `keep_run_i` low, `halt_i` or `stop_i` high freezes the count. When the mode ends, counting resumes from the held value.
- R8: With `keep_run_i` low, `osc_stopped_i` high freezes the count without clearing it.
- R9: With `keep_run_i` high, counting continues while halt, stop and oscillator-stopped are asserted.
- R10: `cfg_bad_o` is high exactly when the period code is 000 and the window code is 00.
- R11: While `rst_ni` is low, `rst_req_o` is low and the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow-clock enable tick |
| period_sel_i | input | 3 | Overflow period code |
| window_sel_i | input | 2 | Open-window size code |
| keep_run_i | input | 1 | Power policy: 1 keeps counting in low-power modes |
| halt_i | input | 1 | Halt mode active |
| stop_i | input | 1 | Stop mode active |
| osc_stopped_i | input | 1 | Slow oscillator stopped by software |
| wr_i | input | 1 | Restart-register write strobe |
| wr_data_i | input | 8 | Restart-register write data |
| rst_req_o | output | 1 | One-cycle reset request |
| win_open_o | output | 1 | Restart window currently open |
| cfg_bad_o | output | 1 | Prohibited period/window combination |

## Verification
A vector table steps through several period and window code pairs from a zero count. For each pair it records the tick at which the window opens and the tick of the overflow. This separates errors in the exponent decode from errors in the quarter-period thresholds. Key and non-key writes are placed one tick before and exactly at the window edge, and inside the open window. These show whether the key compare and the window gate are each checked. The power inputs are raised partway through a period under both policy values, and the remaining time to overflow is measured. A freeze that holds the count gives a shorter remaining time than one that clears it, and a freeze that was never applied gives a shorter time again.

// File: rtl/wdt_win_pkg.sv
package wdt_win_pkg;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned WIN_W = 2;
  localparam int unsigned DAT_W = 8;
  localparam logic [DAT_W-1:0] KICK_KEY = 8'hAC;
endpackage

// File: rtl/wdt_win_limit.sv
module wdt_win_limit
  import wdt_win_pkg::*;
#(
  parameter  int unsigned MIN_EXP = 10,
  localparam int unsigned NUM_SEL = 1 << SEL_W,
  localparam int unsigned LIM_W   = MIN_EXP + NUM_SEL
) (
  input  logic [SEL_W-1:0] period_sel_i,
  input  logic [WIN_W-1:0] window_sel_i,
  output logic [LIM_W-1:0] limit_o,
  output logic [LIM_W-1:0] open_from_o,
  output logic             cfg_bad_o
);
  logic [LIM_W-1:0] lim_tab [NUM_SEL];
  logic [LIM_W-1:0] quarter;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_lim
    assign lim_tab[g] = LIM_W'(1) << (MIN_EXP + g);
  end

  assign limit_o = lim_tab[period_sel_i];
  assign quarter = limit_o >> 2;

  // open region = last (w+1) quarters of the period
  always_comb begin
    unique case (window_sel_i)
      2'd0:    open_from_o = limit_o - quarter;
      2'd1:    open_from_o = limit_o >> 1;
      2'd2:    open_from_o = quarter;
      default: open_from_o = '0;
    endcase
  end

  assign cfg_bad_o = (period_sel_i == '0) && (window_sel_i == '0);
endmodule

// File: rtl/wdt_win_gate.sv
module wdt_win_gate (
  input  logic tick_i,
  input  logic keep_run_i,
  input  logic halt_i,
  input  logic stop_i,
  input  logic osc_stopped_i,
  output logic run_o
);
  logic sleeping;
  assign sleeping = halt_i | stop_i | osc_stopped_i;
  assign run_o    = tick_i & (keep_run_i | ~sleeping);
endmodule

// File: rtl/wdt_win_core.sv
module wdt_win_core
  import wdt_win_pkg::*;
#(
  parameter int unsigned LIM_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             wr_i,
  input  logic [DAT_W-1:0] wr_data_i,
  input  logic [LIM_W-1:0] limit_i,
  input  logic [LIM_W-1:0] open_from_i,
  output logic             rst_req_o,
  output logic             win_open_o
);
  logic [LIM_W-1:0] cnt_q;
  logic             key_ok;
  logic             at_end;

  assign win_open_o = cnt_q >= open_from_i;
  assign key_ok     = (wr_data_i == KICK_KEY) && win_open_o;
  assign at_end     = cnt_q >= (limit_i - LIM_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      rst_req_o <= 1'b0;
    end else if (wr_i) begin
      cnt_q     <= '0;
      rst_req_o <= ~key_ok;
    end else if (run_i && at_end) begin
      cnt_q     <= '0;
      rst_req_o <= 1'b1;
    end else begin
      if (run_i) cnt_q <= cnt_q + LIM_W'(1);
      rst_req_o <= 1'b0;
    end
  end

  p_in_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < limit_i);

  p_overflow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wr_i && cnt_q == limit_i - LIM_W'(1)) |=> rst_req_o);

  p_req_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> cnt_q == '0);

  p_kick_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_data_i == KICK_KEY && win_open_o) |=> (!rst_req_o && cnt_q == '0));

  p_closed_kick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_data_i == KICK_KEY && !win_open_o) |=> rst_req_o);

  p_bad_key_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_data_i != KICK_KEY) |=> rst_req_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_win.sv
module wdt_win
  import wdt_win_pkg::*;
#(
  parameter int unsigned MIN_EXP = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] period_sel_i,
  input  logic [WIN_W-1:0] window_sel_i,
  input  logic             keep_run_i,
  input  logic             halt_i,
  input  logic             stop_i,
  input  logic             osc_stopped_i,
  input  logic             wr_i,
  input  logic [DAT_W-1:0] wr_data_i,
  output logic             rst_req_o,
  output logic             win_open_o,
  output logic             cfg_bad_o
);
  localparam int unsigned LIM_W = MIN_EXP + (1 << SEL_W);

  logic [LIM_W-1:0] limit;
  logic [LIM_W-1:0] open_from;
  logic             run;

  wdt_win_limit #(.MIN_EXP(MIN_EXP)) u_limit (
    .period_sel_i(period_sel_i),
    .window_sel_i(window_sel_i),
    .limit_o     (limit),
    .open_from_o (open_from),
    .cfg_bad_o   (cfg_bad_o)
  );

  wdt_win_gate u_gate (
    .tick_i       (tick_i),
    .keep_run_i   (keep_run_i),
    .halt_i       (halt_i),
    .stop_i       (stop_i),
    .osc_stopped_i(osc_stopped_i),
    .run_o        (run)
  );

  wdt_win_core #(.LIM_W(LIM_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .wr_i       (wr_i),
    .wr_data_i  (wr_data_i),
    .limit_i    (limit),
    .open_from_i(open_from),
    .rst_req_o  (rst_req_o),
    .win_open_o (win_open_o)
  );

  // frozen under policy 0 -> no overflow can fire
  p_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!keep_run_i && (halt_i || stop_i || osc_stopped_i) && !wr_i) |=> !rst_req_o);

  p_sleep_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (keep_run_i && tick_i) |-> run);
endmodule

// File: tb/wdt_win_tb.sv
module wdt_win_tb;
  localparam int unsigned MIN_EXP = 4;

  typedef struct packed {
    logic [2:0]  p;
    logic [1:0]  w;
    logic [31:0] ticks;
    logic [31:0] open;
  } vec_t;

  // period code, window code, ticks to overflow, tick at which window opens
  localparam vec_t VEC [6] = '{
    '{3'd0, 2'd3, 32'd16,   32'd0},
    '{3'd1, 2'd0, 32'd32,   32'd24},
    '{3'd2, 2'd1, 32'd64,   32'd32},
    '{3'd3, 2'd2, 32'd128,  32'd32},
    '{3'd5, 2'd2, 32'd512,  32'd128},
    '{3'd7, 2'd1, 32'd2048, 32'd1024}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] psel = '0;
  logic [1:0] wsel = '0;
  logic       keep = 1'b0;
  logic       halt = 1'b0;
  logic       stop = 1'b0;
  logic       osc = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdat = '0;
  logic       rst_req;
  logic       win_open;
  logic       cfg_bad;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wdt_win #(.MIN_EXP(MIN_EXP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .period_sel_i(psel), .window_sel_i(wsel), .keep_run_i(keep),
    .halt_i(halt), .stop_i(stop), .osc_stopped_i(osc),
    .wr_i(wr), .wr_data_i(wdat),
    .rst_req_o(rst_req), .win_open_o(win_open), .cfg_bad_o(cfg_bad)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start(input logic [2:0] p, input logic [1:0] w, input logic k);
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; wr = 1'b0; halt = 1'b0; stop = 1'b0; osc = 1'b0;
    psel = p; wsel = w; keep = k;
    @(negedge clk);
    rst_n = 1'b1; tick = 1'b1;
  endtask

  task automatic run_ticks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic kick(input logic [7:0] d);
    wr = 1'b1; wdat = d;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic count_to_ovf(output int n);
    n = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end while (!rst_req && n < 5000);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    // R11 reset state
    @(negedge clk);
    chk("R11 rst_req in reset", int'(rst_req), 0);
    chk("R11 window closed at zero count", int'(win_open), 0);

    // R1/R6 table walk
    for (int i = 0; i < 6; i++) begin
      int first_open;
      start(VEC[i].p, VEC[i].w, 1'b0);
      first_open = win_open ? 0 : -1;
      n = 0;
      do begin
        @(posedge clk);
        @(negedge clk);
        n++;
        if (first_open < 0 && win_open && !rst_req) first_open = n;
      end while (!rst_req && n < 5000);
      chk("R1 overflow tick", n, int'(VEC[i].ticks));
      chk("R6 window open tick", first_open, int'(VEC[i].open));
    end

    // R2 pulse width and restart
    start(3'd0, 2'd1, 1'b0);
    count_to_ovf(n);
    chk("R2 first overflow", n, 16);
    run_ticks(1);
    chk("R2 pulse one cycle", int'(rst_req), 0);
    count_to_ovf(n);
    chk("R2 restart from zero", n, 15);

    // R1 ticks gate counting
    start(3'd0, 2'd1, 1'b0);
    run_ticks(4);
    tick = 1'b0;
    run_ticks(30);
    chk("R1 no tick no overflow", int'(rst_req), 0);
    tick = 1'b1;
    count_to_ovf(n);
    chk("R1 remaining after idle", n, 12);

    // R6 window edge, R3 key accepted
    start(3'd0, 2'd1, 1'b0);
    run_ticks(7);
    chk("R6 closed at 7", int'(win_open), 0);
    run_ticks(1);
    chk("R6 open at 8", int'(win_open), 1);
    kick(8'hAC);
    chk("R3 key in window no reset", int'(rst_req), 0);
    chk("R3 count cleared", int'(win_open), 0);
    count_to_ovf(n);
    chk("R3 full period after key", n, 16);

    // R4 key in closed window, one tick before edge
    start(3'd0, 2'd1, 1'b0);
    run_ticks(7);
    kick(8'hAC);
    chk("R4 key while closed", int'(rst_req), 1);

    // R5 wrong byte inside open window and while closed
    start(3'd0, 2'd1, 1'b0);
    run_ticks(10);
    kick(8'h55);
    chk("R5 wrong byte open window", int'(rst_req), 1);
    start(3'd0, 2'd1, 1'b0);
    run_ticks(2);
    kick(8'hAD);
    chk("R5 wrong byte closed window", int'(rst_req), 1);

    // R7 halt freezes, resumes from held value
    start(3'd0, 2'd1, 1'b0);
    run_ticks(5);
    halt = 1'b1;
    run_ticks(40);
    chk("R7 halt no overflow", int'(rst_req), 0);
    halt = 1'b0;
    count_to_ovf(n);
    chk("R7 halt resume", n, 11);

    // R7 stop keeps open window
    start(3'd0, 2'd1, 1'b0);
    run_ticks(9);
    stop = 1'b1;
    run_ticks(40);
    chk("R7 stop holds open window", int'(win_open), 1);
    stop = 1'b0;
    count_to_ovf(n);
    chk("R7 stop resume", n, 7);

    // R8 oscillator stopped
    start(3'd0, 2'd1, 1'b0);
    run_ticks(3);
    osc = 1'b1;
    run_ticks(40);
    chk("R8 osc stop no overflow", int'(rst_req), 0);
    osc = 1'b0;
    count_to_ovf(n);
    chk("R8 osc resume", n, 13);

    // R9 keep-running policy
    start(3'd0, 2'd1, 1'b1);
    halt = 1'b1; stop = 1'b1; osc = 1'b1;
    count_to_ovf(n);
    chk("R9 counts in low power", n, 16);

    // R10 illegal config flag
    psel = 3'd0; wsel = 2'd0; #1;
    chk("R10 000/00 flagged", int'(cfg_bad), 1);
    psel = 3'd0; wsel = 2'd1; #1;
    chk("R10 000/01 legal", int'(cfg_bad), 0);
    psel = 3'd1; wsel = 2'd0; #1;
    chk("R10 001/00 legal", int'(cfg_bad), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule